// File: doc/BRIEF.md
# Region Representative Reuse Tracker

This block decides, for every cache access, whether a missing line is installed or bypassed, while only a small fraction of accesses update reuse state. The address space is cut into fixed regions of consecutive lines. One slot in each region is the representative. Only accesses to that slot consult the per-line replacement policy, which sits outside this block. Every other line in the region copies the representative's most recent verdict and never writes state of its own.

The verdicts are kept in a small direct-mapped on-chip table. The table is indexed by the low bits of the region number and tagged with the remaining region bits. Each representative access writes its verdict into the table. A follower miss reads the table. A follower whose region has no valid matching entry installs. Two saturating counters, one for representative decisions and one for follower decisions, show how much state-update traffic the scheme avoids.

Requests arrive as line addresses, that is, byte addresses with the line offset already removed. Each request gives a registered decision exactly two cycles later. Requests may arrive on every cycle.

Top module: `region_follow_tracker`

## Requirements
- R1: After reset, `dec_valid` is 0 and both `rep_count` and `fol_count` are 0.
- R2: A request accepted at a clock edge (`req_valid`=1) produces exactly one decision with `dec_valid`=1 two edges later. Back-to-back requests produce back-to-back decisions, and `dec_valid` is 0 when there was no request.
- R3: A request is a representative when its slot, `req_line[5:0]`, equals the parameter `REP_SLOT` (default 0). `dec_is_rep` reports this, 1 for a representative and 0 for a follower.
- R4: On a representative miss, `dec_bypass` equals the `pol_bypass` that was given with the request (1 = bypass, 0 = install).
- R5: On a hit (`req_hit`=1), `dec_bypass` is 0, for both representatives and followers.
- R6: On a follower miss, `dec_bypass` equals the verdict of the latest representative access of the same region. This holds even when that access was accepted in the cycle just before the follower.
- R7: A follower miss in a region whose table entry has never been written installs (`dec_bypass`=0).
- R8: The table index is `req_line[11:6]` and the tag is `req_line[25:12]`. A representative access overwrites the entry even when it belongs to another region. Followers of the displaced region then install.
- R9: Followers never write the table, and their `pol_bypass` input has no effect on any decision.
- R10: `rep_count` rises by one for each representative decision and `fol_count` by one for each follower decision. Both counts change on the edge where `dec_valid` is set.
- R11: Each counter saturates at its all-ones value (`2**CNT_W-1`) and then holds.
- R12: A representative hit still records its `pol_bypass` into the table, so that later follower misses of its region follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_line | input | LINE_W (26) | Line address of the access |
| req_hit | input | 1 | Access hit in the cache |
| pol_bypass | input | 1 | Per-line policy verdict, used for representatives only |
| dec_valid | output | 1 | Decision valid |
| dec_bypass | output | 1 | 1 = bypass, 0 = install |
| dec_is_rep | output | 1 | Decision belongs to a representative access |
| rep_count | output | CNT_W (16) | Saturating count of representative decisions |
| fol_count | output | CNT_W (16) | Saturating count of follower decisions |

## Verification
The bench applies four input patterns, and each one tells a different cause apart:
- **Representative misses with both policy verdicts.** These show that the output comes from the policy and not from the table.
- **Follower misses after a representative verdict, including one accepted the cycle before.** These separate correct copying from a stale table read.
- **Followers of untouched regions and of regions displaced by an aliasing representative.** These show that the tag compare and the install default work, rather than a match on index alone.
- **Hits and followers driven with a contrary `pol_bypass`.** These show that neither can leak into a decision or into the table.

Finally, the bench checks the counters against its own tallies, and a long run of followers drives the narrowed counter into saturation.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  typedef enum logic {
    ACT_INSTALL = 1'b0,
    ACT_BYPASS  = 1'b1
  } act_e;

  function automatic act_e pick_act(input logic hit, input logic rep,
                                    input logic pol, input logic match,
                                    input logic stored);
    if (hit)       return ACT_INSTALL;
    else if (rep)  return act_e'(pol);
    else if (match) return act_e'(stored);
    else           return ACT_INSTALL;
  endfunction
endpackage

// File: rtl/rrt_line_split.sv
module rrt_line_split #(
  parameter int LINE_W       = 26,
  parameter int REGION_LINES = 64,
  parameter int ENTRIES      = 64,
  parameter int REP_SLOT     = 0
) (
  input  logic [LINE_W-1:0]                 line,
  output logic [$clog2(ENTRIES)-1:0]        idx,
  output logic [LINE_W-$clog2(REGION_LINES)-$clog2(ENTRIES)-1:0] tag,
  output logic                              is_rep
);
  localparam int SLOT_W = $clog2(REGION_LINES);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_W  = LINE_W - SLOT_W - IDX_W;

  logic [SLOT_W-1:0] slot;

  always_comb begin
    slot   = line[SLOT_W-1:0];
    idx    = line[SLOT_W +: IDX_W];
    tag    = line[SLOT_W+IDX_W +: TAG_W];
    is_rep = (slot == SLOT_W'(REP_SLOT));
  end
endmodule

// File: rtl/rrt_bypass_table.sv
module rrt_bypass_table #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(ENTRIES)-1:0]  idx,
  input  logic                        wr_en,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        wr_byp,
  output logic                        rd_vld,
  output logic [TAG_W-1:0]            rd_tag,
  output logic                        rd_byp
);
  localparam int DATA_W = TAG_W + 1;

  logic [DATA_W-1:0]  mem [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [DATA_W-1:0]  rd_q;

  // Tag and verdict: plain RAM with registered read-first port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= {wr_tag, wr_byp};
    rd_q <= mem[idx];
  end

  // Valid flags live in flops so they can be cleared by reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld[idx] <= 1'b1;
      rd_vld <= vld[idx];
    end
  end

  always_comb begin
    rd_tag = rd_q[DATA_W-1:1];
    rd_byp = rd_q[0];
  end

  // An entry never reads as valid before a write has reached it.
  p_empty_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) |-> !rd_vld));
endmodule

// File: rtl/rrt_sat_counter.sv
module rrt_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  p_step_r10: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!inc) |=> $stable(cnt));
  p_hold_top_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == TOP));
endmodule

// File: rtl/rrt_decide.sv
module rrt_decide #(
  parameter int TAG_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic             s1_rep,
  input  logic             s1_hit,
  input  logic             s1_pol,
  input  logic [TAG_W-1:0] s1_tag,
  input  logic             rd_vld,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             rd_byp,
  output logic             dec_valid,
  output logic             dec_bypass,
  output logic             dec_is_rep
);
  import rrt_pkg::*;

  logic match;
  act_e act;

  always_comb begin
    match = rd_vld && (rd_tag == s1_tag);
    act   = pick_act(s1_hit, s1_rep, s1_pol, match, rd_byp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_bypass <= 1'b0;
      dec_is_rep <= 1'b0;
    end else begin
      dec_valid  <= s1_valid;
      dec_bypass <= s1_valid && (act == ACT_BYPASS);
      dec_is_rep <= s1_valid && s1_rep;
    end
  end

  p_out_follows_stage_r2: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> dec_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !dec_valid);
  p_rep_uses_policy_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_rep && !s1_hit) |=> (dec_bypass == $past(s1_pol)));
  p_hit_installs_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_hit) |=> !dec_bypass);
  p_empty_installs_r7: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_rep && !rd_vld) |=> !dec_bypass);
endmodule

// File: rtl/region_follow_tracker.sv
module region_follow_tracker #(
  parameter int LINE_W       = 26,
  parameter int REGION_LINES = 64,
  parameter int ENTRIES      = 64,
  parameter int REP_SLOT     = 0,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic             req_hit,
  input  logic             pol_bypass,
  output logic             dec_valid,
  output logic             dec_bypass,
  output logic             dec_is_rep,
  output logic [CNT_W-1:0] rep_count,
  output logic [CNT_W-1:0] fol_count
);
  localparam int SLOT_W = $clog2(REGION_LINES);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_W  = LINE_W - SLOT_W - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             is_rep;
  logic             wr_en;

  logic             s1_valid, s1_rep, s1_hit, s1_pol;
  logic [TAG_W-1:0] s1_tag;
  logic             rd_vld, rd_byp;
  logic [TAG_W-1:0] rd_tag;

  rrt_line_split #(
    .LINE_W(LINE_W), .REGION_LINES(REGION_LINES),
    .ENTRIES(ENTRIES), .REP_SLOT(REP_SLOT)
  ) i_split (
    .line(req_line), .idx(idx), .tag(tag), .is_rep(is_rep)
  );

  // Only representative accesses write replacement state.
  assign wr_en = req_valid && is_rep;

  rrt_bypass_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_table (
    .clk(clk), .rst(rst), .idx(idx), .wr_en(wr_en),
    .wr_tag(tag), .wr_byp(pol_bypass),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_byp(rd_byp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_rep   <= 1'b0;
      s1_hit   <= 1'b0;
      s1_pol   <= 1'b0;
      s1_tag   <= '0;
    end else begin
      s1_valid <= req_valid;
      s1_rep   <= req_valid && is_rep;
      s1_hit   <= req_hit;
      s1_pol   <= pol_bypass;
      s1_tag   <= tag;
    end
  end

  rrt_decide #(.TAG_W(TAG_W)) i_decide (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .s1_rep(s1_rep), .s1_hit(s1_hit),
    .s1_pol(s1_pol), .s1_tag(s1_tag),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_byp(rd_byp),
    .dec_valid(dec_valid), .dec_bypass(dec_bypass), .dec_is_rep(dec_is_rep)
  );

  rrt_sat_counter #(.CNT_W(CNT_W)) i_rep_cnt (
    .clk(clk), .rst(rst), .inc(s1_valid && s1_rep), .cnt(rep_count)
  );
  rrt_sat_counter #(.CNT_W(CNT_W)) i_fol_cnt (
    .clk(clk), .rst(rst), .inc(s1_valid && !s1_rep), .cnt(fol_count)
  );

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> s1_valid);
  p_rep_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_rep) |-> ($past(req_line[SLOT_W-1:0]) == SLOT_W'(REP_SLOT)));
  p_one_kind_r10: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (($past(rep_count) != rep_count) || ($past(fol_count) != fol_count)
                   || (&rep_count) || (&fol_count)));
endmodule

// File: tb/test_region_follow_tracker.sv
module test_region_follow_tracker;
  localparam int LINE_W = 26;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_hit, pol_bypass;
  logic [LINE_W-1:0] req_line;
  logic dec_valid, dec_bypass, dec_is_rep;
  logic [CNT_W-1:0] rep_count, fol_count;

  int checks = 0;
  int errors = 0;
  int exp_rep = 0;
  int exp_fol = 0;

  always #2.5 clk = ~clk;

  region_follow_tracker #(.LINE_W(LINE_W), .CNT_W(CNT_W)) i_region_follow_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
    .req_hit(req_hit), .pol_bypass(pol_bypass),
    .dec_valid(dec_valid), .dec_bypass(dec_bypass), .dec_is_rep(dec_is_rep),
    .rep_count(rep_count), .fol_count(fol_count)
  );

  function automatic logic [LINE_W-1:0] mk(input int region, input int slot);
    return LINE_W'((region << 6) | slot);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Single access; returns after the decision is on the outputs.
  task automatic access(input int region, input int slot, input logic hit,
                        input logic pol, output logic byp, output logic rep);
    @(negedge clk);
    req_valid = 1'b1; req_line = mk(region, slot); req_hit = hit; pol_bypass = pol;
    @(negedge clk);
    req_valid = 1'b0; pol_bypass = ~pol;
    @(negedge clk);
    chk("R2 decision valid", int'(dec_valid), 1);
    byp = dec_bypass; rep = dec_is_rep;
    if (slot == 0) exp_rep++; else exp_fol++;
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b0; req_line = '0; req_hit = 1'b0; pol_bypass = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dec_valid after reset", int'(dec_valid), 0);
    chk("R1 rep_count after reset", int'(rep_count), 0);
    chk("R1 fol_count after reset", int'(fol_count), 0);
  endtask

  task automatic t_rep_miss();
    logic b, r;
    access(5, 0, 1'b0, 1'b1, b, r);
    chk("R3 representative flag", int'(r), 1);
    chk("R4 rep miss bypass", int'(b), 1);
    access(5, 0, 1'b0, 1'b0, b, r);
    chk("R4 rep miss install", int'(b), 0);
  endtask

  task automatic t_follow();
    logic b, r;
    access(5, 0, 1'b0, 1'b1, b, r);
    access(5, 7, 1'b0, 1'b0, b, r);
    chk("R3 follower flag", int'(r), 0);
    chk("R6 follower copies bypass", int'(b), 1);
    access(5, 0, 1'b0, 1'b0, b, r);
    access(5, 63, 1'b0, 1'b1, b, r);
    chk("R6 follower copies install", int'(b), 0);
  endtask

  task automatic t_hit();
    logic b, r;
    access(6, 0, 1'b0, 1'b1, b, r);
    access(6, 9, 1'b1, 1'b1, b, r);
    chk("R5 follower hit installs", int'(b), 0);
    access(7, 0, 1'b1, 1'b1, b, r);
    chk("R5 rep hit installs", int'(b), 0);
    access(7, 4, 1'b0, 1'b0, b, r);
    chk("R12 rep hit recorded for followers", int'(b), 1);
  endtask

  task automatic t_empty();
    logic b, r;
    access(9, 3, 1'b0, 1'b1, b, r);
    chk("R7 untouched region installs", int'(b), 0);
  endtask

  task automatic t_alias();
    logic b, r;
    access(10, 0, 1'b0, 1'b1, b, r);
    access(74, 0, 1'b0, 1'b0, b, r);
    access(10, 5, 1'b0, 1'b0, b, r);
    chk("R8 displaced region installs", int'(b), 0);
    access(74, 0, 1'b0, 1'b1, b, r);
    access(74, 2, 1'b0, 1'b0, b, r);
    chk("R8 new owner followed", int'(b), 1);
    access(10, 6, 1'b0, 1'b0, b, r);
    chk("R8 tag mismatch still installs", int'(b), 0);
  endtask

  task automatic t_ignore();
    logic b, r;
    access(12, 0, 1'b0, 1'b1, b, r);
    access(12, 8, 1'b0, 1'b0, b, r);
    chk("R9 follower pol ignored", int'(b), 1);
    access(12, 9, 1'b0, 1'b0, b, r);
    chk("R9 table unchanged by follower", int'(b), 1);
  endtask

  task automatic t_b2b();
    @(negedge clk);
    req_valid = 1'b1; req_line = mk(20, 0); req_hit = 1'b0; pol_bypass = 1'b1;
    @(negedge clk);
    req_line = mk(20, 11); pol_bypass = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 first of pair valid", int'(dec_valid), 1);
    chk("R4 first of pair bypass", int'(dec_bypass), 1);
    @(negedge clk);
    chk("R2 second of pair valid", int'(dec_valid), 1);
    chk("R6 follower right after rep", int'(dec_bypass), 1);
    @(negedge clk);
    chk("R2 no spurious decision", int'(dec_valid), 0);
    exp_rep++; exp_fol++;
  endtask

  task automatic t_counts();
    chk("R10 rep_count", int'(rep_count), exp_rep);
    chk("R10 fol_count", int'(fol_count), exp_fol);
  endtask

  task automatic t_sat();
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      req_valid = 1'b1; req_line = mk(30, 1 + (i % 63)); req_hit = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 fol_count saturates", int'(fol_count), 255);
    chk("R11 rep_count unaffected", int'(rep_count), exp_rep);
  endtask

  initial begin
    t_reset();
    t_rep_miss();
    t_follow();
    t_hit();
    t_empty();
    t_alias();
    t_ignore();
    t_b2b();
    t_counts();
    t_sat();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule